// File: doc/BRIEF.md
# Ordered Probe-Role Candidate Generator

This block feeds a pin-discovery scan engine with candidate wirings. Four probe roles (test clock, mode select, data in, data out) must each be placed on a different channel of an N-channel probe header. The block walks every ordered placement of the four roles on distinct channels and hands them to the engine one at a time over a valid/ready handshake.

A channel-enable mask, captured when the sweep is started, narrows the search. Any placement that touches a disabled channel is never offered. Each candidate is given both as four channel indices and as a 16-bit word of four nibbles. It also carries a running index. A one-cycle done pulse closes the sweep.

Candidates are produced by a four-digit counter that runs in base N, filtered as the digits change. No table of placements is stored. The channel count is a parameter, up to 16, because one channel index must fit in a nibble.

Top module: `role_perm_gen`

## Requirements
- R1: A one-cycle `start_i` while idle, with at least four bits of `chan_en_i` set, begins a sweep. The first candidate offered is the lowest in the order of R2. With all channels enabled it is tck=0, tms=1, tdi=2, tdo=3, so `cand_packed_o` = 0x0123.
- R2: Candidates come in strictly increasing lexicographic order of (tck, tms, tdi, tdo). The tdo index varies fastest and the tck index slowest, so each `cand_packed_o` is numerically greater than the one before it.
- R3: In every candidate the four indices are pairwise distinct and below N_CH. Every ordered placement of the four roles on distinct enabled channels is offered exactly once, which gives 11880 candidates for 12 enabled channels.
- R4: No candidate uses a channel whose bit in `chan_en_i` was 0 at the accepted start. Changes to `chan_en_i` during a sweep have no effect.
- R5: `cand_packed_o` holds tck in bits [15:12], tms in [11:8], tdi in [7:4] and tdo in [3:0]. The upper byte therefore holds the clock and mode-select indices.
- R6: While `cand_valid_o` is high and `cand_ready_i` is low, the candidate, its packed word and its index stay unchanged. The next candidate appears only after an accept, which is a cycle with valid and ready both high.
- R7: `cand_idx_o` is 0 for the first candidate of a sweep and rises by one on each accept. With all 12 channels enabled it is 11879 on the final candidate.
- R8: `done_o` is a one-cycle pulse. It is raised once per sweep, after the last candidate has been accepted and the rest of the search space has been passed. It is never high together with `cand_valid_o`.
- R9: A start with fewer than four enabled channels raises `done_o` in the cycle after the start, and no candidate is offered.
- R10: `start_i` is ignored while a sweep is in progress. The sequence and the index continue undisturbed.
- R11: After reset, `cand_valid_o` and `done_o` are low and `cand_idx_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a sweep (sampled while idle) |
| chan_en_i | input | N_CH | Channels allowed in the sweep, captured at start |
| cand_valid_o | output | 1 | Candidate on the outputs is valid |
| cand_ready_i | input | 1 | Scan engine accepts the candidate |
| cand_tck_o | output | 4 | Channel for the test-clock role |
| cand_tms_o | output | 4 | Channel for the mode-select role |
| cand_tdi_o | output | 4 | Channel for the data-in role |
| cand_tdo_o | output | 4 | Channel for the data-out role |
| cand_packed_o | output | 16 | Four indices packed as nibbles |
| cand_idx_o | output | CNT_W | Count of candidates accepted before this one |
| done_o | output | 1 | One-cycle end-of-sweep pulse |

## Verification
The search delay between candidates depends on how many illegal tuples the counter passes. For this reason the bench does not predict the cycle in which valid rises. It samples on every falling edge and compares each offered candidate with an arithmetic model of the next legal placement. Stability under back-pressure is checked on the sample after a refused offer, since an accept takes effect at the next rising edge. The short-mask done pulse is due exactly one cycle after the start edge and must be gone one cycle later. For the end of a normal sweep, the bench requires done before a bounded timeout, with no extra candidate before it, and requires done to drop on the following sample.

// File: rtl/role_perm_pkg.sv
package role_perm_pkg;
  localparam int unsigned N_ROLE = 4;
  localparam int unsigned NIB_W  = 4;

  typedef enum logic [1:0] {ST_IDLE, ST_SEARCH, ST_OFFER} perm_state_e;

  function automatic int unsigned perm_count(int unsigned n);
    return (n < N_ROLE) ? 0 : n * (n - 1) * (n - 2) * (n - 3);
  endfunction
endpackage

// File: rtl/role_perm_digit.sv
// One base-N_CH digit of the role odometer.
module role_perm_digit #(
  parameter int unsigned N_CH = 12,
  parameter int unsigned W    = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         adv_i,
  output logic [W-1:0] val_o,
  output logic         top_o
);
  localparam logic [W-1:0] MAX = W'(N_CH - 1);

  logic [W-1:0] val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     val_q <= '0;
    else if (clr_i)  val_q <= '0;
    else if (adv_i)  val_q <= (val_q == MAX) ? '0 : val_q + 1'b1;
  end

  assign val_o = val_q;
  assign top_o = (val_q == MAX);
endmodule

// File: rtl/role_perm_filter.sv
// Legal when all digits are distinct and on enabled channels.
module role_perm_filter
  import role_perm_pkg::*;
#(
  parameter int unsigned N_CH = 12
) (
  input  logic [N_ROLE-1:0][NIB_W-1:0] digit_i,
  input  logic [N_CH-1:0]              mask_i,
  output logic                         legal_o
);
  logic [N_ROLE-1:0] en_ok;

  for (genvar k = 0; k < N_ROLE; k++) begin : g_en
    always_comb begin
      en_ok[k] = 1'b0;
      for (int c = 0; c < N_CH; c++) begin
        if (digit_i[k] == NIB_W'(c) && mask_i[c]) en_ok[k] = 1'b1;
      end
    end
  end

  logic distinct;
  always_comb begin
    distinct = 1'b1;
    for (int i = 0; i < N_ROLE; i++) begin
      for (int j = i + 1; j < N_ROLE; j++) begin
        if (digit_i[i] == digit_i[j]) distinct = 1'b0;
      end
    end
  end

  assign legal_o = distinct && (&en_ok);
endmodule

// File: rtl/role_perm_ctrl.sv
// Sequencing: search, offer, done, and accept counting.
module role_perm_ctrl
  import role_perm_pkg::*;
#(
  parameter int unsigned N_CH  = 12,
  parameter int unsigned CNT_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [N_CH-1:0]  chan_en_i,
  input  logic             legal_i,
  input  logic             last_i,
  input  logic             ready_i,
  output logic             load_o,
  output logic             step_o,
  output logic             valid_o,
  output logic             done_o,
  output logic [CNT_W-1:0] idx_o
);
  perm_state_e state_q, state_d;
  logic        done_q;
  logic [CNT_W-1:0] idx_q;
  int unsigned n_en;
  logic enough, accept, finish;

  always_comb begin
    n_en = 0;
    for (int c = 0; c < N_CH; c++) n_en += int'(chan_en_i[c]);
  end

  assign enough = (n_en >= N_ROLE);
  assign accept = (state_q == ST_OFFER) && ready_i;
  assign load_o = (state_q == ST_IDLE) && start_i && enough;
  assign step_o = ((state_q == ST_SEARCH) && !legal_i && !last_i) || (accept && !last_i);
  assign finish = ((state_q == ST_IDLE) && start_i && !enough)
               || ((state_q == ST_SEARCH) && !legal_i && last_i)
               || (accept && last_i);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (load_o) state_d = ST_SEARCH;
      ST_SEARCH: if (legal_i) state_d = ST_OFFER;
                 else if (last_i) state_d = ST_IDLE;
      ST_OFFER:  if (accept) state_d = last_i ? ST_IDLE : ST_SEARCH;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      done_q  <= finish;
      if (load_o)      idx_q <= '0;
      else if (accept) idx_q <= idx_q + 1'b1;
    end
  end

  assign valid_o = (state_q == ST_OFFER);
  assign done_o  = done_q;
  assign idx_o   = idx_q;
endmodule

// File: rtl/role_perm_gen.sv
module role_perm_gen
  import role_perm_pkg::*;
#(
  parameter  int unsigned N_CH  = 12,
  localparam int unsigned CNT_W = $clog2(perm_count(N_CH) + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [N_CH-1:0]  chan_en_i,
  output logic             cand_valid_o,
  input  logic             cand_ready_i,
  output logic [3:0]       cand_tck_o,
  output logic [3:0]       cand_tms_o,
  output logic [3:0]       cand_tdi_o,
  output logic [3:0]       cand_tdo_o,
  output logic [15:0]      cand_packed_o,
  output logic [CNT_W-1:0] cand_idx_o,
  output logic             done_o
);
  if (N_CH < N_ROLE || N_CH > (1 << NIB_W)) begin : g_bad_cfg
    initial $error("role_perm_gen: N_CH out of range");
  end

  logic [N_CH-1:0] mask_q;
  logic load, step, legal, last;
  logic [N_ROLE:0] carry;
  logic [N_ROLE-1:0] top;
  logic [N_ROLE-1:0][NIB_W-1:0] digit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mask_q <= '0;
    else if (load) mask_q <= chan_en_i;
  end

  // digit 0 = tdo (fastest), digit N_ROLE-1 = tck (slowest)
  assign carry[0] = 1'b1;
  for (genvar k = 0; k < N_ROLE; k++) begin : g_digit
    role_perm_digit #(.N_CH(N_CH), .W(NIB_W)) u_digit (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (load),
      .adv_i  (step && carry[k]),
      .val_o  (digit[k]),
      .top_o  (top[k])
    );
    assign carry[k+1] = carry[k] && top[k];
  end
  assign last = carry[N_ROLE];

  role_perm_filter #(.N_CH(N_CH)) u_filter (
    .digit_i (digit),
    .mask_i  (mask_q),
    .legal_o (legal)
  );

  role_perm_ctrl #(.N_CH(N_CH), .CNT_W(CNT_W)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .chan_en_i (chan_en_i),
    .legal_i   (legal),
    .last_i    (last),
    .ready_i   (cand_ready_i),
    .load_o    (load),
    .step_o    (step),
    .valid_o   (cand_valid_o),
    .done_o    (done_o),
    .idx_o     (cand_idx_o)
  );

  assign cand_tck_o    = digit[3];
  assign cand_tms_o    = digit[2];
  assign cand_tdi_o    = digit[1];
  assign cand_tdo_o    = digit[0];
  assign cand_packed_o = {digit[3], digit[2], digit[1], digit[0]};
endmodule

// File: rtl/role_perm_chk.sv
module role_perm_chk #(
  parameter int unsigned N_CH  = 12,
  parameter int unsigned CNT_W = 14
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic             ready_i,
  input logic             done_i,
  input logic [15:0]      packed_i,
  input logic [CNT_W-1:0] idx_i,
  input logic [N_CH-1:0]  mask_i
);
  logic        have_prev;
  logic [15:0] last_pk;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      have_prev <= 1'b0;
      last_pk   <= '0;
    end else if (done_i) begin
      have_prev <= 1'b0;
    end else if (valid_i && ready_i) begin
      have_prev <= 1'b1;
      last_pk   <= packed_i;
    end
  end

  function automatic logic nib_ok(logic [3:0] n, logic [N_CH-1:0] m);
    logic ok;
    ok = 1'b0;
    for (int c = 0; c < N_CH; c++) if (n == 4'(c) && m[c]) ok = 1'b1;
    return ok;
  endfunction

  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !ready_i |=> valid_i && $stable(packed_i) && $stable(idx_i));

  assert_idx_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && ready_i |=> idx_i == $past(idx_i) + 1'b1);

  assert_distinct_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> packed_i[15:12] != packed_i[11:8] && packed_i[15:12] != packed_i[7:4]
             && packed_i[15:12] != packed_i[3:0] && packed_i[11:8] != packed_i[7:4]
             && packed_i[11:8] != packed_i[3:0] && packed_i[7:4] != packed_i[3:0]);

  assert_enabled_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> nib_ok(packed_i[15:12], mask_i) && nib_ok(packed_i[11:8], mask_i)
             && nib_ok(packed_i[7:4], mask_i) && nib_ok(packed_i[3:0], mask_i));

  assert_order_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && have_prev |-> packed_i > last_pk);

  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);

  assert_done_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_i && valid_i));
endmodule

bind role_perm_gen role_perm_chk #(.N_CH(N_CH), .CNT_W(CNT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (cand_valid_o),
  .ready_i  (cand_ready_i),
  .done_i   (done_o),
  .packed_i (cand_packed_o),
  .idx_i    (cand_idx_o),
  .mask_i   (mask_q)
);

// File: tb/tb_role_perm_gen.sv
module tb_role_perm_gen;
  localparam int N = 12;
  localparam int CNT_W = $clog2(N * (N - 1) * (N - 2) * (N - 3) + 1);

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, ready = 1'b0;
  logic [N-1:0] chan_en = '0;
  logic valid, done;
  logic [3:0] tck, tms, tdi, tdo;
  logic [15:0] pk;
  logic [CNT_W-1:0] idx;

  int n_chk = 0, n_bad = 0;
  bit ended = 0;

  always #5 clk = ~clk;

  role_perm_gen #(.N_CH(N)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .chan_en_i(chan_en),
    .cand_valid_o(valid), .cand_ready_i(ready),
    .cand_tck_o(tck), .cand_tms_o(tms), .cand_tdi_o(tdi), .cand_tdo_o(tdo),
    .cand_packed_o(pk), .cand_idx_o(idx), .done_o(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  function automatic int ref_next(logic [N-1:0] m, int from);
    for (int c = from; c < N * N * N * N; c++) begin
      int a = c / (N * N * N);
      int b = (c / (N * N)) % N;
      int x = (c / N) % N;
      int y = c % N;
      if (a != b && a != x && a != y && b != x && b != y && x != y
          && m[a] && m[b] && m[x] && m[y]) return c;
    end
    return -1;
  endfunction

  function automatic int exp_count(logic [N-1:0] m);
    int n = $countones(m);
    return (n < 4) ? 0 : n * (n - 1) * (n - 2) * (n - 3);
  endfunction

  // mode 0: always ready; mode 1: refuse every third sample
  task automatic sweep(input logic [N-1:0] m, input int mode, input bit poke);
    int cur, seen, t, expn, e_pk, last_idx;
    bit stalled, poked, got_done;
    logic [15:0] hold_pk;
    cur = ref_next(m, 0);
    expn = exp_count(m);
    seen = 0; t = 0; stalled = 0; poked = 0; got_done = 0; hold_pk = '0; last_idx = -1;
    chan_en = m; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chan_en = ~m;  // must not matter (R4)
    while (t < 60000) begin
      if (done) begin
        check(!valid, "R8 done with valid", int'(valid), 0);
        got_done = 1;
        break;
      end
      if (valid) begin
        e_pk = ((cur / (N * N * N)) << 12) | (((cur / (N * N)) % N) << 8)
             | (((cur / N) % N) << 4) | (cur % N);
        if (seen == 0) check(pk == 16'(e_pk), "R1 first candidate", int'(pk), e_pk);
        if (stalled) check(pk == hold_pk, "R6 hold under back-pressure", int'(pk), int'(hold_pk));
        check(cur >= 0, "R3 extra candidate", int'(pk), -1);
        check(pk == 16'(e_pk), "R2 R4 candidate order", int'(pk), e_pk);
        check({tck, tms, tdi, tdo} == 16'(e_pk), "R5 field packing",
              int'({tck, tms, tdi, tdo}), e_pk);
        check(int'(idx) == seen, "R7 running index", int'(idx), seen);
        ready = (mode == 0) ? 1'b1 : (t % 3 != 0);
        if (ready) begin
          seen++; last_idx = int'(idx); cur = (cur < 0) ? -1 : ref_next(m, cur + 1); stalled = 0;
        end else begin
          stalled = 1; hold_pk = pk;
        end
      end else begin
        ready = 1'b0;
      end
      if (poke && !poked && seen == 5) begin
        start = 1'b1; chan_en = '1; poked = 1;  // R10
      end
      @(negedge clk);
      start = 1'b0;
      t++;
    end
    ready = 1'b0;
    check(got_done, "R8 done reached", int'(got_done), 1);
    check(seen == expn, poke ? "R3 R10 candidate count" : "R3 candidate count", seen, expn);
    check(cur == -1, "R3 all placements offered", cur, -1);
    if (expn > 0) check(last_idx == expn - 1, "R7 final index", last_idx, expn - 1);
    @(negedge clk);
    check(!done, "R8 single-cycle done", int'(done), 0);
  endtask

  task automatic short_start(input logic [N-1:0] m);
    chan_en = m; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(done, "R9 immediate done", int'(done), 1);
    check(!valid, "R9 no candidate", int'(valid), 0);
    @(negedge clk);
    check(!done, "R9 done pulse width", int'(done), 0);
    for (int i = 0; i < 30; i++) begin
      check(!valid, "R9 stays idle", int'(valid), 0);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!valid, "R11 reset valid", int'(valid), 0);
    check(!done, "R11 reset done", int'(done), 0);
    check(idx == 0, "R11 reset index", int'(idx), 0);
    rst_n = 1'b1;
    @(negedge clk);
    sweep('1, 0, 0);
    check(1, "R1 full-mask sweep", 0, 0);
    sweep(12'b1011_0100_1011, 1, 0);
    sweep(12'b0000_1111_0000, 1, 1);
    sweep(12'b1000_0001_1001, 0, 0);
    short_start(12'b0001_0000_0011);
    short_start('0);
    sweep(12'b1111_0000_0000, 1, 0);
    if (!ended) begin
      ended = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule